// File: doc/BRIEF.md
# Up/Down Reload Timer with Clock-Out

A 16-bit timer/counter built from two cascaded byte halves. A 16-bit reload register of the same width works with it. The count advances on an internal timebase tick, or on falling edges of an external count pin.

Four behaviours are selectable:
- plain up-counting with automatic reload;
- up/down counting, where an external direction pin picks the direction and an extra flag toggles on every wrap, acting as a 17th count bit;
- reload or capture on a falling edge of the same pin, used as a trigger;
- a clock-output mode that produces a 50% duty square wave.

Software reaches the block through a simple byte write port and a combinational read port. It sees two sticky flags and one interrupt request line. Both external pins pass through a two-flop synchronizer before any edge or level is used, so their effect lags the pins by a fixed latency.

Top module: `utr_timer`

## Requirements
- R1: Up-counting with up/down mode off and capture bit clear: each enabled step adds one. A step taken at FFFFh loads the reload register into the counter, sets the overflow flag (control bit 7) and raises `irq_o`.
- R2: In up/down mode (mode bit 0) with the direction pin high, the counter counts up. A wrap at FFFFh loads the reload value, sets the overflow flag and toggles the external flag (control bit 6).
- R3: In up/down mode with the direction pin low, the counter counts down. A step taken while the counter equals the reload register loads FFFFh, sets the overflow flag and toggles the external flag.
- R4: In up/down mode the external flag never contributes to `irq_o`, and it toggles on every wrap in either direction.
- R5: With up/down mode off, the external-enable bit (control bit 3) set and the capture bit (control bit 0) clear, a synchronized falling edge on the direction pin loads the reload value into the counter and sets the external flag, which raises `irq_o`.
- R6: With the capture bit set, such a falling edge copies the counter into the reload register and sets the external flag. In this mode an up-count wrap from FFFFh goes to 0000h and still sets the overflow flag.
- R7: With the external-enable bit clear, edges on the direction pin change neither the counter, the reload register nor the external flag.
- R8: Clock-out mode (mode bit 1, count-select bit clear) counts on `clko_tick_i`. Each wrap reloads the counter and toggles `clk_out_o`, so with a tick every cycle the pin toggles every 65536−reload cycles. Clock-out wraps never set the overflow flag.
- R9: With the count-select bit (control bit 1) set, the counter advances once per falling edge of the count pin and ignores `tmr_tick_i`.
- R10: With the run bit (control bit 2) clear, no tick or count-pin edge changes the counter.
- R11: Both flags are sticky and cleared only by a software write to the control register. When a hardware set falls in the same cycle as a software clear, the flag ends up set.
- R12: After reset the control register, the mode register, the counter, the reload register, `irq_o` and `clk_out_o` all read zero. Register addresses: 0 control, 1 mode, 2/3 counter low/high, 4/5 reload low/high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmr_tick_i | input | 1 | Prescaled timebase step enable for timer mode |
| clko_tick_i | input | 1 | Oscillator/2 step enable for clock-out mode |
| cnt_pin_i | input | 1 | External count pin, counted on falling edges |
| dir_pin_i | input | 1 | External direction level / trigger edge pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| ovf_flag_o | output | 1 | Overflow/underflow flag |
| ext_flag_o | output | 1 | External / 17th-bit flag |
| irq_o | output | 1 | Interrupt request |
| clk_out_o | output | 1 | Square wave output of clock-out mode |

## Verification
Two functions can land in one cycle: a software write to the control register that clears both flags, and a counter wrap that sets the overflow flag. The bench provokes the collision by asserting the write strobe and a single tick in the same cycle, with the counter held at FFFFh. It then judges the result by reading back a set overflow flag and a counter reloaded from the reload register. The bench also sweeps start values next to each wrap point in every mode and computes the expected count, flag and toggle period arithmetically.

// File: rtl/utr_pkg.sv
package utr_pkg;
  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] A_CTRL   = 3'd0;
  localparam logic [AW-1:0] A_MODE   = 3'd1;
  localparam logic [AW-1:0] A_CNT_LO = 3'd2;
  localparam logic [AW-1:0] A_RLD_LO = 3'd4;

  // control register bit positions
  localparam int unsigned B_OVF  = 7;
  localparam int unsigned B_EXT  = 6;
  localparam int unsigned B_EXEN = 3;
  localparam int unsigned B_RUN  = 2;
  localparam int unsigned B_CSEL = 1;
  localparam int unsigned B_CAP  = 0;
  // mode register bit positions
  localparam int unsigned B_CLKO = 1;
  localparam int unsigned B_UPDN = 0;

  typedef struct packed {
    logic exen;
    logic run;
    logic csel;
    logic cap;
    logic clko;
    logic updn;
  } cfg_t;
endpackage

// File: rtl/utr_pin_sync.sv
module utr_pin_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] fall_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES:0] sh;
    // lines idle high; reset to ones so release creates no edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh <= '1;
      else         sh <= {sh[STAGES-1:0], pin_i[b]};
    end
    assign level_o[b] = sh[STAGES-1];
    assign fall_o[b]  = sh[STAGES] & ~sh[STAGES-1];
  end
endmodule

// File: rtl/utr_ctrl_regs.sv
module utr_ctrl_regs
  import utr_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              ovf_set_i,
  input  logic              ext_set_i,
  input  logic              ext_tgl_i,
  output cfg_t              cfg_o,
  output logic              ovf_o,
  output logic              ext_o
);
  cfg_t cfg_q, cfg_d;
  logic ovf_q, ovf_d, ext_q, ext_d;
  logic ctrl_wr, mode_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
  assign mode_wr = wr_en_i && (wr_addr_i == A_MODE);

  always_comb begin
    cfg_d = cfg_q;
    if (ctrl_wr) begin
      cfg_d.exen = wr_data_i[B_EXEN];
      cfg_d.run  = wr_data_i[B_RUN];
      cfg_d.csel = wr_data_i[B_CSEL];
      cfg_d.cap  = wr_data_i[B_CAP];
    end
    if (mode_wr) begin
      cfg_d.clko = wr_data_i[B_CLKO];
      cfg_d.updn = wr_data_i[B_UPDN];
    end
  end

  // hardware events override a same-cycle software write
  always_comb begin
    ovf_d = ovf_q;
    ext_d = ext_q;
    if (ctrl_wr) begin
      ovf_d = wr_data_i[B_OVF];
      ext_d = wr_data_i[B_EXT];
    end
    if (ovf_set_i) ovf_d = 1'b1;
    if (ext_tgl_i) ext_d = ~ext_q;
    if (ext_set_i) ext_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ovf_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      ovf_q <= ovf_d;
      ext_q <= ext_d;
    end
  end

  assign cfg_o = cfg_q;
  assign ovf_o = ovf_q;
  assign ext_o = ext_q;
endmodule

// File: rtl/utr_count_core.sv
module utr_count_core
  import utr_pkg::*;
#(
  parameter int unsigned HALF_W = 8,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              up_i,
  input  logic              clko_act_i,
  input  logic              updn_act_i,
  input  logic              cap_i,
  input  logic              trig_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [HALF_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic              ovf_set_o,
  output logic              ext_tgl_o,
  output logic              clk_tgl_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic at_top, at_floor;

  assign at_top   = (cnt_q == '1);
  assign at_floor = (cnt_q == rld_q);

  always_comb begin
    cnt_d     = cnt_q;
    rld_d     = rld_q;
    ovf_set_o = 1'b0;
    ext_tgl_o = 1'b0;
    clk_tgl_o = 1'b0;
    if (step_i) begin
      if (clko_act_i) begin
        if (at_top) begin
          cnt_d     = rld_q;
          clk_tgl_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (updn_act_i && !up_i) begin
        if (at_floor) begin
          cnt_d     = '1;
          ovf_set_o = 1'b1;
          ext_tgl_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        if (at_top) begin
          cnt_d     = (cap_i && !updn_act_i) ? '0 : rld_q;
          ovf_set_o = 1'b1;
          ext_tgl_o = updn_act_i;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
    if (trig_i) begin
      if (cap_i) rld_d = cnt_q;
      else       cnt_d = rld_q;
    end
    // byte writes from software take the last word
    for (int h = 0; h < 2; h++) begin
      if (wr_en_i && (wr_addr_i == A_CNT_LO + AW'(h)))
        cnt_d[h*HALF_W +: HALF_W] = wr_data_i;
      if (wr_en_i && (wr_addr_i == A_RLD_LO + AW'(h)))
        rld_d[h*HALF_W +: HALF_W] = wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
endmodule

// File: rtl/utr_timer.sv
module utr_timer
  import utr_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_tick_i,
  input  logic              clko_tick_i,
  input  logic              cnt_pin_i,
  input  logic              dir_pin_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [HALF_W-1:0] rd_data_o,
  output logic              ovf_flag_o,
  output logic              ext_flag_o,
  output logic              irq_o,
  output logic              clk_out_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  cfg_t             cfg;
  logic [1:0]       pin_lvl, pin_fall;
  logic             dir_lvl, dir_fall, cnt_fall;
  logic             clko_act, updn_act, run_en, step, trig;
  logic             ovf_set, ext_tgl, clk_tgl;
  logic             ovf, ext;
  logic [CNT_W-1:0] cnt, rld;
  logic             clk_out_q;

  utr_pin_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({dir_pin_i, cnt_pin_i}),
    .level_o(pin_lvl),
    .fall_o (pin_fall)
  );
  assign dir_lvl  = pin_lvl[1];
  assign dir_fall = pin_fall[1];
  assign cnt_fall = pin_fall[0];

  assign clko_act = cfg.clko && !cfg.csel;
  assign updn_act = cfg.updn && !clko_act;
  assign run_en   = cfg.run;
  assign step     = run_en && (clko_act ? clko_tick_i
                                        : (cfg.csel ? cnt_fall : tmr_tick_i));
  assign trig     = cfg.exen && !updn_act && dir_fall;

  utr_ctrl_regs #(.HALF_W(HALF_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .ovf_set_i(ovf_set),
    .ext_set_i(trig),
    .ext_tgl_i(ext_tgl),
    .cfg_o    (cfg),
    .ovf_o    (ovf),
    .ext_o    (ext)
  );

  utr_count_core #(.HALF_W(HALF_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .up_i      (dir_lvl),
    .clko_act_i(clko_act),
    .updn_act_i(updn_act),
    .cap_i     (cfg.cap),
    .trig_i    (trig),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt),
    .rld_o     (rld),
    .ovf_set_o (ovf_set),
    .ext_tgl_o (ext_tgl),
    .clk_tgl_o (clk_tgl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      clk_out_q <= 1'b0;
    else if (clk_tgl) clk_out_q <= ~clk_out_q;
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL:       rd_data_o = HALF_W'({ovf, ext, 2'b00, cfg.exen, cfg.run, cfg.csel, cfg.cap});
      A_MODE:       rd_data_o = HALF_W'({cfg.clko, cfg.updn});
      A_CNT_LO:     rd_data_o = cnt[HALF_W-1:0];
      A_CNT_LO + 1: rd_data_o = cnt[CNT_W-1:HALF_W];
      A_RLD_LO:     rd_data_o = rld[HALF_W-1:0];
      A_RLD_LO + 1: rd_data_o = rld[CNT_W-1:HALF_W];
      default:      rd_data_o = '0;
    endcase
  end

  assign ovf_flag_o = ovf;
  assign ext_flag_o = ext;
  assign irq_o      = ovf || (ext && !updn_act);
  assign clk_out_o  = clk_out_q;
endmodule

// File: rtl/utr_checker.sv
module utr_checker
  import utr_pkg::*;
#(
  parameter int unsigned HALF_W = 8,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] rld_i,
  input logic             ovf_i,
  input logic             ext_i,
  input logic             irq_i,
  input logic             clko_act_i,
  input logic             updn_act_i,
  input logic             run_i,
  input logic             trig_i,
  input logic             clk_out_i
);
  logic ctrl_wr, cnt_wr;
  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
  assign cnt_wr  = wr_en_i && ((wr_addr_i == A_CNT_LO) || (wr_addr_i == A_CNT_LO + 1));

  // R1 R3: a hardware overflow only follows the top value or the reload floor
  p_wrap_source_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ovf_i) && !$past(ctrl_wr)) |-> ($past(cnt_i) == '1 || $past(cnt_i) == $past(rld_i)));

  p_updn_no_ext_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (updn_act_i && !ovf_i) |-> !irq_i);

  p_clko_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clko_act_i && !ovf_i && !ctrl_wr) |=> !ovf_i);

  p_clko_pin_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clko_act_i |=> $stable(clk_out_i));

  p_run_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr && !trig_i) |=> $stable(cnt_i));

  p_ext_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_i && !ctrl_wr && !updn_act_i) |=> ext_i);

  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !ctrl_wr) |=> ovf_i);
endmodule

bind utr_timer utr_checker #(.HALF_W(HALF_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .cnt_i     (cnt),
  .rld_i     (rld),
  .ovf_i     (ovf),
  .ext_i     (ext),
  .irq_i     (irq_o),
  .clko_act_i(clko_act),
  .updn_act_i(updn_act),
  .run_i     (run_en),
  .trig_i    (trig),
  .clk_out_i (clk_out_o)
);

// File: tb/tb_utr_timer.sv
module tb_utr_timer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tmr_tick = 1'b0, clko_tick = 1'b0;
  logic       cnt_pin = 1'b1, dir_pin = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       ovf_flag, ext_flag, irq, clk_out;

  int n_vec = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  utr_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .tmr_tick_i(tmr_tick), .clko_tick_i(clko_tick),
    .cnt_pin_i(cnt_pin), .dir_pin_i(dir_pin), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ovf_flag_o(ovf_flag), .ext_flag_o(ext_flag), .irq_o(irq), .clk_out_o(clk_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set16(input logic [2:0] base, input logic [15:0] v);
    wr(base, v[7:0]);
    wr(base + 3'd1, v[15:8]);
  endtask

  task automatic rd8(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rd16(input logic [2:0] base, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd8(base, lo);
    rd8(base + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tmr_tick = 1'b1;
      repeat (n) @(negedge clk);
      tmr_tick = 1'b0;
    end
  endtask

  task automatic dir_fall_pulse();
    @(negedge clk); dir_pin = 1'b1;
    repeat (4) @(negedge clk);
    dir_pin = 1'b0;
    repeat (5) @(negedge clk);
    dir_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state
    for (int a = 0; a < 6; a++) begin
      rd8(3'(a), b);
      chk($sformatf("R12 reg %0d", a), b, 8'h00);
    end
    chk("R12 irq", irq, 1'b0);
    chk("R12 clk_out", clk_out, 1'b0);

    // R10 run bit clear: ticks do nothing
    set16(3'd2, 16'h0100);
    ticks(5);
    rd16(3'd2, v);
    chk("R10 stopped count", v, 16'h0100);

    // R1 plain up-count and reload
    for (int k = 0; k < 5; k++) begin
      wr(3'd0, 8'h04);
      set16(3'd4, 16'(k * 16'h0F0F));
      set16(3'd2, 16'hFFFF - 16'(k));
      ticks(k);
      rd16(3'd2, v);
      chk("R1 climb to top", v, 16'hFFFF);
      chk("R1 no early flag", ovf_flag, 1'b0);
      ticks(1);
      rd16(3'd2, v);
      chk("R1 reload on wrap", v, 16'(k * 16'h0F0F));
      chk("R1 overflow flag", ovf_flag, 1'b1);
      chk("R1 irq", irq, 1'b1);
    end

    // R2 up/down mode, counting up
    wr(3'd1, 8'h01);
    for (int k = 0; k < 4; k++) begin
      wr(3'd0, 8'h04);
      set16(3'd4, 16'h1000 + 16'(k * 16'h0111));
      set16(3'd2, 16'hFFFF - 16'(k));
      ticks(k + 1);
      rd16(3'd2, v);
      chk("R2 reload on up wrap", v, 16'h1000 + 16'(k * 16'h0111));
      chk("R2 overflow flag", ovf_flag, 1'b1);
      chk("R2 ext toggled", ext_flag, 1'b1);
      ticks(2);
      rd16(3'd2, v);
      chk("R2 counts up after reload", v, 16'h1002 + 16'(k * 16'h0111));
    end

    // R3 counting down to the reload floor
    dir_pin = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      wr(3'd0, 8'h04);
      set16(3'd4, 16'h2000 + 16'(k * 16'h0035));
      set16(3'd2, 16'h2000 + 16'(k * 16'h0035) + 16'(k));
      ticks(k);
      rd16(3'd2, v);
      chk("R3 down to floor", v, 16'h2000 + 16'(k * 16'h0035));
      chk("R3 no flag at floor", ovf_flag, 1'b0);
      ticks(1);
      rd16(3'd2, v);
      chk("R3 underflow loads top", v, 16'hFFFF);
      chk("R3 overflow flag", ovf_flag, 1'b1);
      chk("R3 ext toggled", ext_flag, 1'b1);
      ticks(1);
      rd16(3'd2, v);
      chk("R3 keeps counting down", v, 16'hFFFE);
    end

    // R4 external flag in up/down mode: no irq, toggles back
    wr(3'd0, 8'h44);
    chk("R4 ext set by write", ext_flag, 1'b1);
    chk("R4 ext gives no irq", irq, 1'b0);
    rd16(3'd4, v);
    set16(3'd2, v);
    ticks(1);
    chk("R4 ext toggles back", ext_flag, 1'b0);
    chk("R4 underflow flag", ovf_flag, 1'b1);
    dir_pin = 1'b1;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    repeat (4) @(negedge clk);

    // R5 trigger reload
    set16(3'd4, 16'hABCD);
    set16(3'd2, 16'h0007);
    wr(3'd0, 8'h08);
    dir_fall_pulse();
    rd16(3'd2, v);
    chk("R5 trigger reload", v, 16'hABCD);
    chk("R5 ext flag", ext_flag, 1'b1);
    chk("R5 irq from ext", irq, 1'b1);

    // R6 capture
    wr(3'd0, 8'h09);
    set16(3'd2, 16'h1234);
    dir_fall_pulse();
    rd16(3'd4, v);
    chk("R6 captured value", v, 16'h1234);
    rd16(3'd2, v);
    chk("R6 counter untouched", v, 16'h1234);
    chk("R6 ext flag", ext_flag, 1'b1);
    wr(3'd0, 8'h05);
    set16(3'd2, 16'hFFFF);
    ticks(1);
    rd16(3'd2, v);
    chk("R6 capture-mode wrap to zero", v, 16'h0000);
    chk("R6 overflow flag", ovf_flag, 1'b1);

    // R7 external enable clear: edge ignored
    wr(3'd0, 8'h00);
    set16(3'd4, 16'h5555);
    set16(3'd2, 16'h0011);
    dir_fall_pulse();
    rd16(3'd2, v);
    chk("R7 counter unchanged", v, 16'h0011);
    rd16(3'd4, v);
    chk("R7 reload unchanged", v, 16'h5555);
    chk("R7 ext stays clear", ext_flag, 1'b0);

    // R8 clock-out period sweep
    for (int k = 0; k < 7; k++) begin
      int per, waited;
      logic prev;
      wr(3'd0, 8'h00);
      set16(3'd4, 16'hFFFF - 16'(k));
      set16(3'd2, 16'hFFFF - 16'(k));
      wr(3'd1, 8'h02);
      wr(3'd0, 8'h04);
      @(negedge clk); clko_tick = 1'b1;
      prev = clk_out; waited = 0;
      while (clk_out == prev && waited < 200) begin @(negedge clk); waited++; end
      prev = clk_out; per = 0;
      while (clk_out == prev && per < 200) begin @(negedge clk); per++; end
      chk("R8 half period", per, k + 1);
      chk("R8 no overflow flag", ovf_flag, 1'b0);
      chk("R8 no irq", irq, 1'b0);
      clko_tick = 1'b0;
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
    end

    // R9 counter mode on pin edges, timebase ignored
    set16(3'd2, 16'h0010);
    wr(3'd0, 8'h06);
    @(negedge clk); tmr_tick = 1'b1;
    for (int i = 0; i < 7; i++) begin
      cnt_pin = 1'b1; repeat (3) @(negedge clk);
      cnt_pin = 1'b0; repeat (3) @(negedge clk);
    end
    cnt_pin = 1'b1; repeat (4) @(negedge clk);
    tmr_tick = 1'b0;
    rd16(3'd2, v);
    chk("R9 pin edge count", v, 16'h0017);

    // R11 same-cycle software clear and hardware set
    wr(3'd0, 8'h04);
    set16(3'd4, 16'h0300);
    set16(3'd2, 16'hFFFF);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h04; tmr_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tmr_tick = 1'b0;
    rd16(3'd2, v);
    chk("R11 wrap in clear cycle", v, 16'h0300);
    chk("R11 hardware set wins", ovf_flag, 1'b1);
    wr(3'd0, 8'h04);
    chk("R11 software clear", ovf_flag, 1'b0);
    chk("R11 irq drops", irq, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule